// File: doc/BRIEF.md
# Strap-Selected NAND Chain Connectivity Test Pin

This block gives a board tester a way to prove that every digital input pin of the chip is soldered and reachable. The inputs feed a chain of two-input NAND gates. When the chip starts in test mode, the result of the chain replaces the normal value on one shared output pin. The tester drives all inputs low and then raises them one at a time, holding each one high. Each step flips the shared pin, so one probe on that pin shows the connectivity of every input.

Test mode is selected by a strap input. The strap is read once, on the first clock after the power-on reset is released. After that, the selection is frozen until the next reset. In normal mode the shared pin carries the chip's functional output value without change. The chain is purely combinational. Only the mode selection is held in a flop.

Top module: `conn_test_pinmux`

## Requirements
- R1: While `rst_n` is low, and on the clock edge that samples it low, the block is in normal mode and `pin_out` equals `func_out`, whatever `strap_in` is.
- R2: If `strap_in` is 1 at the first rising edge of `clk` that samples `rst_n` high, the block enters test mode from the following cycle.
- R3: If `strap_in` is 0 at that same first edge, the block stays in normal mode.
- R4: After that first edge, changes on `strap_in` have no effect on the mode until `rst_n` is driven low again.
- R5: Driving `rst_n` low again returns the block to normal mode. The strap is then sampled afresh after the next release.
- R6: In test mode, `pin_out` equals the end of the chain. Define s = 1. Then for i = 0 up to TREE_W-1, set s = NOT(`tree_in`[i] AND s). Bit TREE_W-1 is the input nearest the output.
- R7: In test mode, with every `tree_in` bit at 0, `pin_out` is 1.
- R8: In test mode, start from all zeros. Raise `tree_in` bits one by one and hold them high, from bit TREE_W-1 down to bit 0. `pin_out` toggles at every step. With all bits high, `pin_out` is 1 when TREE_W is even and 0 when TREE_W is odd.
- R9: In test mode, `func_out` has no effect on `pin_out`.
- R10: In normal mode, `pin_out` equals `func_out`, and `tree_in` has no effect on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used only to sample the strap |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_in | input | 1 | Mode strap; 1 at the first clock after reset selects test mode |
| tree_in | input | TREE_W | Digital input pins observed by the NAND chain |
| func_out | input | 1 | Normal-mode value for the shared pin |
| pin_out | output | 1 | Value driven onto the shared pin |

## Verification
The bench builds the block with TREE_W = 7, which differs from the default of 8. The odd width means the final all-high pattern must give 0 on the pin, which catches a chain whose parity is off by one stage. Seven stages also make a walking-one run short enough to repeat beside many random vectors.

The bench resets the block three times, with the strap at different values. This reaches both modes and confirms that the strap is re-sampled after each reset. It also confirms that strap changes after capture have no effect on the mode.

// File: rtl/ctm_pkg.sv
// Shared types for the connectivity test pin block.
// Assumes: nothing beyond IEEE 1800-2017.
package ctm_pkg;
    typedef enum logic {
        MODE_FUNC = 1'b0,
        MODE_TREE = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/ctm_strap_latch.sv
// Captures the mode strap once, on the first clock after the power-on
// reset is released, and holds the resulting mode until the next reset.
// Assumes: rst_n is synchronous and active low; strap_in is stable
// around that first edge (pad-level synchronisation is not this block's job).
module ctm_strap_latch
    import ctm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strap_in,
    output pin_mode_e mode
);
    logic sampled_q;

    // Purpose: record the strap exactly once per reset and then freeze it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sampled_q <= 1'b0;
            mode      <= MODE_FUNC;
        end else if (!sampled_q) begin
            sampled_q <= 1'b1;
            mode      <= strap_in ? MODE_TREE : MODE_FUNC;
        end
    end

    // R1: a reset edge always leaves the block in normal mode.
    p_reset_func_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_FUNC));

    // R2/R3: the mode taken is the strap seen at the capture edge.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sampled_q) |-> (mode == ($past(strap_in) ? MODE_TREE : MODE_FUNC)));

    // R4: once captured, the mode never moves until reset.
    p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled_q && $past(sampled_q)) |-> $stable(mode));
endmodule

// File: rtl/ctm_nand_chain.sv
// Serial chain of two-input NAND gates over the observed inputs.
// Stage 0 ties its spare input high, and stage k combines tree_in[k]
// with the result of stage k-1. The last stage, TREE_W-1, is nearest the output.
// Assumes: TREE_W >= 1; purely combinational, no delay modelled.
module ctm_nand_chain #(
    parameter int TREE_W = 8
) (
    input  logic [TREE_W-1:0] tree_in,
    output logic              tree_out
);
    localparam int  LAST         = TREE_W - 1;
    localparam logic ALL_HIGH_OUT = ((TREE_W % 2) == 0) ? 1'b1 : 1'b0;

    logic [TREE_W-1:0] stage;

    // Purpose: build one NAND per input, each fed by the previous stage.
    for (genvar g = 0; g < TREE_W; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage[g] = ~(tree_in[g] & 1'b1);
        end else begin : g_link
            assign stage[g] = ~(tree_in[g] & stage[g-1]);
        end
    end

    assign tree_out = stage[LAST];

    // Purpose: check the two fixed points of the chain against its inputs.
    always_comb begin
        if (tree_in == '0) begin
            p_all_low_r7: assert (tree_out == 1'b1);
        end
        if (tree_in == '1) begin
            p_all_high_r8: assert (tree_out == ALL_HIGH_OUT);
        end
    end
endmodule

// File: rtl/ctm_pin_select.sv
// Chooses what drives the shared pin: the functional value in normal
// mode, or the chain result in test mode.
// Assumes: mode comes from a flop, so the select never glitches.
module ctm_pin_select
    import ctm_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      func_val,
    input  logic      tree_val,
    output logic      pin_val
);
    // Purpose: two-way select for the shared pin.
    always_comb begin
        unique case (mode)
            MODE_TREE: pin_val = tree_val;
            default:   pin_val = func_val;
        endcase
    end
endmodule

// File: rtl/conn_test_pinmux.sv
// Top of the connectivity test pin block: the strap latch, the NAND
// chain over the input pins, and the select for the shared output pin.
// Assumes: synchronous active-low power-on reset; TREE_W >= 1.
module conn_test_pinmux
    import ctm_pkg::*;
#(
    parameter int TREE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_in,
    input  logic [TREE_W-1:0] tree_in,
    input  logic              func_out,
    output logic              pin_out
);
    pin_mode_e mode;
    logic      chain_val;

    ctm_strap_latch u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .mode     (mode)
    );

    ctm_nand_chain #(.TREE_W(TREE_W)) u_chain (
        .tree_in  (tree_in),
        .tree_out (chain_val)
    );

    ctm_pin_select u_sel (
        .mode     (mode),
        .func_val (func_out),
        .tree_val (chain_val),
        .pin_val  (pin_out)
    );

    // R1: the edge after a reset edge shows the functional value on the pin.
    p_reset_pin_func_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_out == func_out));
endmodule

// File: tb/conn_test_pinmux_tb.sv
module conn_test_pinmux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 7;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         strap_in;
    logic [W-1:0] tree_in;
    logic         func_out;
    logic         pin_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    conn_test_pinmux #(.TREE_W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .tree_in  (tree_in),
        .func_out (func_out),
        .pin_out  (pin_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic chain_ref(input logic [W-1:0] v);
        logic s;
        s = 1'b1;
        for (int i = 0; i < W; i++) s = ~(v[i] & s);
        return s;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: pin_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // Drive inputs at a negedge, then let the combinational path settle.
    task automatic drive(input logic [W-1:0] t, input logic f);
        @(negedge clk);
        tree_in  = t;
        func_out = f;
        #1;
    endtask

    // Reset for a few cycles, then release with the chosen strap held over the capture edge.
    task automatic power_on(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_in = ~strap;
        repeat (2) @(negedge clk);
        strap_in = strap;
        rst_n = 1'b1;
        @(posedge clk);
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - failures, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic f;
        logic prev;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; strap_in = 1'b1; tree_in = '0; func_out = 1'b1;

        // R1: in reset the pin follows func_out even with strap high.
        settle();
        check("R1", pin_out, 1'b1);
        func_out = 1'b0; tree_in = '1; #1;
        check("R1", pin_out, 1'b0);

        // R3: strap low at capture -> normal mode; R4: later strap high ignored.
        power_on(1'b0);
        strap_in = 1'b1;
        for (int i = 0; i < 30; i++) begin
            v = W'($urandom); f = 1'($urandom);
            strap_in = 1'($urandom);
            drive(v, f);
            check("R3/R10", pin_out, f);
        end
        strap_in = 1'b1;
        drive('0, 1'b0);
        check("R4 strap ignored", pin_out, 1'b0);
        drive('1, 1'b1);
        check("R10 tree no effect", pin_out, 1'b1);

        // R5/R2: reset again, strap high -> test mode.
        power_on(1'b1);
        strap_in = 1'b0;
        drive('0, 1'b0);
        check("R2/R7 all low", pin_out, 1'b1);
        drive('0, 1'b1);
        check("R9 func no effect", pin_out, 1'b1);

        // R8: walking one from nearest input to farthest.
        v = '0;
        prev = 1'b1;
        for (int k = W - 1; k >= 0; k--) begin
            v[k] = 1'b1;
            drive(v, 1'($urandom));
            check("R8 toggle", pin_out, ~prev);
            prev = pin_out;
        end
        check("R8 all high (odd width)", pin_out, 1'b0);

        // R6/R9/R4: random vectors, random func_out and strap.
        for (int i = 0; i < 60; i++) begin
            v = W'($urandom); f = 1'($urandom);
            strap_in = 1'($urandom);
            drive(v, f);
            check("R6/R9", pin_out, chain_ref(v));
        end
        drive('1, 1'b1);
        check("R4 still test mode", pin_out, 1'b0);

        // R5: reset with strap low returns to normal mode.
        power_on(1'b0);
        drive('0, 1'b0);
        check("R5 back to normal", pin_out, 1'b0);
        drive('1, 1'b1);
        check("R5/R10", pin_out, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - failures, checks);
        $finish;
    end
endmodule